// File: doc/BRIEF.md
# Hourly Chime and Note Playback Controller

This block runs the top-of-the-hour alarm event in a clock and thermometer system that runs from a 12 MHz clock. It watches the BCD minute and hour values from the timekeeping counter. When the minutes reach 00 and the hour value is a valid 24-hour BCD value, it issues a single transmit request that carries the current temperature byte. It then raises a freeze flag, so that the display stops updating the time and the temperature.

While the event runs, the low nibble of each received serial byte selects one of sixteen notes. On a fixed interval the controller loads the newest selection into a square-wave tone generator. It returns the buzzer to silence halfway through each interval. The event ends when bytes stop arriving for a gap timeout, or when a hard cap on the event length expires, whichever comes first. At the end the buzzer goes silent and the freeze is released.

The serializer, the deserializer and the time counter are outside this block. The 16-entry pitch table is built in. A shift parameter scales the periods down for short simulations.

Top module: `chime_ctrl`

## Requirements
- R1: In the clock cycle after the block samples minutes equal to 8'h00 while idle, with a valid hour, the block starts an event. At that edge `tx_valid` and `freeze` go high.
- R2: `tx_valid` is high for exactly one cycle per event. `tx_data` carries the `temp_byte` value sampled at the trigger, and it does not change between events.
- R3: `freeze` stays high for the whole event and low while idle. The buzzer is low whenever `freeze` has been low for two consecutive cycles.
- R4: A trigger condition that arises while an event is in progress is ignored. No new event starts until the minutes have left 8'h00 and returned to it.
- R5: The tone period is set by the 4-bit `rx_code` of the most recent byte accepted during the event. The periods for codes 0 to F are 45872, 40858, 36408, 34364, 30612, 27273, 24296, 22931, 20432, 18201, 17180, 15306, 13636, 12148, 11478 and 10215, each shifted right by TONE_SHIFT. Bytes received while idle are discarded. If no byte has been accepted during the event, a silent period of 0 is loaded.
- R6: Counting from the start edge, a note is loaded every NOTE_INTERVAL clocks, and the period is cleared to 0 after a further NOTE_INTERVAL/2 clocks. A period of 0 holds `buzz` low.
- R7: The clock after a new period P is loaded, `buzz` starts a square wave. It is high for the first P/2 clocks of each P-clock cycle and low for the rest.
- R8: If no byte is accepted for GAP_CYCLES clocks, counting from the start or from the last accepted byte, the event ends and `freeze` falls.
- R9: No event lasts longer than CAP_CYCLES clocks. `freeze` is high for at most CAP_CYCLES consecutive cycles, and the buzzer is silenced at the end of the event.
- R10: An hour value outside BCD 00..23 blocks the trigger. Hour 8'h23 is accepted.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| min_bcd | input | 8 | Current minutes, BCD |
| hour_bcd | input | 8 | Current hours, BCD, 24-hour format |
| temp_byte | input | 8 | Temperature byte to report |
| rx_valid | input | 1 | One-cycle strobe for a received serial byte |
| rx_code | input | 4 | Low nibble of the received byte (note code) |
| tx_valid | output | 1 | One-cycle transmit request |
| tx_data | output | 8 | Byte to transmit |
| freeze | output | 1 | Display freeze flag |
| buzz | output | 1 | Buzzer square wave |

## Verification
The trigger, the transmit pulse and the freeze flag are registered. They appear in the cycle after the edge that samples the minute change. The sequencer registers each note load and half-interval clear, and the tone generator adds one more cycle. The buzzer therefore follows a load one cycle after the edge at which the load happens, and it goes silent one cycle after a clear or after the end of the event. Each stimulus task records the cycle number of the edge that samples it. It then queues expected values at absolute cycle numbers computed from those offsets. The monitor compares them in the second half of the matching cycle, away from the clock edge.

// File: rtl/chime_pkg.sv
package chime_pkg;

    localparam int unsigned PITCH_W = 16;
    typedef logic [PITCH_W-1:0] pitch_t;

    function automatic pitch_t pitch_of(input logic [3:0] code);
        pitch_t p;
        case (code)
            4'h0: p = 16'd45872;
            4'h1: p = 16'd40858;
            4'h2: p = 16'd36408;
            4'h3: p = 16'd34364;
            4'h4: p = 16'd30612;
            4'h5: p = 16'd27273;
            4'h6: p = 16'd24296;
            4'h7: p = 16'd22931;
            4'h8: p = 16'd20432;
            4'h9: p = 16'd18201;
            4'hA: p = 16'd17180;
            4'hB: p = 16'd15306;
            4'hC: p = 16'd13636;
            4'hD: p = 16'd12148;
            4'hE: p = 16'd11478;
            default: p = 16'd10215;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/chime_trigger.sv
module chime_trigger (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] min_i,
    input  logic [7:0] hour_i,
    input  logic [7:0] temp_i,
    input  logic       busy_i,
    output logic       start_o,
    output logic       tx_valid_o,
    output logic [7:0] tx_data_o
);

    typedef struct packed {
        logic       seen;
        logic       txv;
        logic [7:0] txd;
    } trig_t;

    trig_t s_d, s_q;
    logic  hour_ok;
    logic  cond;

    always_comb begin
        hour_ok = (hour_i[3:0] <= 4'd9) && (hour_i <= 8'h23);
        cond    = hour_ok && (min_i == 8'h00);
        start_o = cond && !s_q.seen && !busy_i;

        s_d      = s_q;
        s_d.seen = cond;
        s_d.txv  = start_o;
        if (start_o) begin
            s_d.txd = temp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid_o = s_q.txv;
    assign tx_data_o  = s_q.txd;

endmodule

// File: rtl/chime_sequencer.sv
module chime_sequencer
    import chime_pkg::*;
#(
    parameter int unsigned NOTE_INTERVAL = 6_000_000,
    parameter int unsigned GAP_CYCLES    = 24_000_000,
    parameter int unsigned CAP_CYCLES    = 360_000_000,
    parameter int unsigned TONE_SHIFT    = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rx_valid_i,
    input  logic [3:0] rx_code_i,
    output logic       playing_o,
    output pitch_t     period_o
);

    localparam int unsigned IV_W  = $clog2(NOTE_INTERVAL);
    localparam int unsigned GAP_W = $clog2(GAP_CYCLES);
    localparam int unsigned CAP_W = $clog2(CAP_CYCLES);

    typedef logic [IV_W-1:0]  iv_t;
    typedef logic [GAP_W-1:0] gap_t;
    typedef logic [CAP_W-1:0] cap_t;

    localparam iv_t  IV_LAST  = iv_t'(NOTE_INTERVAL - 1);
    localparam iv_t  IV_HALF  = iv_t'(NOTE_INTERVAL / 2 - 1);
    localparam gap_t GAP_LAST = gap_t'(GAP_CYCLES - 1);
    localparam cap_t CAP_LAST = cap_t'(CAP_CYCLES - 1);

    typedef struct packed {
        logic       playing;
        logic       have;
        logic [3:0] code;
        iv_t        iv;
        gap_t       gap;
        cap_t       cap;
        pitch_t     period;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.playing) begin
            if (start_i) begin
                s_d.playing = 1'b1;
                s_d.have    = 1'b0;
                s_d.iv      = '0;
                s_d.gap     = '0;
                s_d.cap     = '0;
                s_d.period  = '0;
            end
        end else begin
            s_d.cap = s_q.cap + 1'b1;
            if (rx_valid_i) begin
                s_d.have = 1'b1;
                s_d.code = rx_code_i;
                s_d.gap  = '0;
            end else begin
                s_d.gap = s_q.gap + 1'b1;
            end
            if (s_q.iv == IV_LAST) begin
                s_d.iv     = '0;
                s_d.period = s_d.have ? pitch_t'(pitch_of(s_d.code) >> TONE_SHIFT) : '0;
            end else begin
                s_d.iv = s_q.iv + 1'b1;
                if (s_q.iv == IV_HALF) begin
                    s_d.period = '0;
                end
            end
            if ((s_q.cap == CAP_LAST) || (!rx_valid_i && (s_q.gap == GAP_LAST))) begin
                s_d.playing = 1'b0;
                s_d.period  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign playing_o = s_q.playing;
    assign period_o  = s_q.period;

endmodule

// File: rtl/chime_tone.sv
module chime_tone
    import chime_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  pitch_t period_i,
    output logic   buzz_o
);

    typedef struct packed {
        pitch_t last;
        pitch_t tc;
        logic   out;
    } tone_t;

    tone_t  s_d, s_q;
    pitch_t half;

    always_comb begin
        half = period_i >> 1;
        s_d  = s_q;
        if (period_i == '0) begin
            s_d.last = '0;
            s_d.tc   = '0;
            s_d.out  = 1'b0;
        end else if (period_i != s_q.last) begin
            s_d.last = period_i;
            s_d.tc   = '0;
            s_d.out  = (half != '0);
        end else begin
            s_d.tc  = (s_q.tc == period_i - 1'b1) ? '0 : s_q.tc + 1'b1;
            s_d.out = (s_d.tc < half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign buzz_o = s_q.out;

endmodule

// File: rtl/chime_ctrl.sv
module chime_ctrl
    import chime_pkg::*;
#(
    parameter int unsigned NOTE_INTERVAL = 6_000_000,
    parameter int unsigned GAP_CYCLES    = 24_000_000,
    parameter int unsigned CAP_CYCLES    = 360_000_000,
    parameter int unsigned TONE_SHIFT    = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] min_bcd,
    input  logic [7:0] hour_bcd,
    input  logic [7:0] temp_byte,
    input  logic       rx_valid,
    input  logic [3:0] rx_code,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       freeze,
    output logic       buzz
);

    logic   start;
    logic   playing;
    pitch_t period;

    chime_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .min_i     (min_bcd),
        .hour_i    (hour_bcd),
        .temp_i    (temp_byte),
        .busy_i    (playing),
        .start_o   (start),
        .tx_valid_o(tx_valid),
        .tx_data_o (tx_data)
    );

    chime_sequencer #(
        .NOTE_INTERVAL(NOTE_INTERVAL),
        .GAP_CYCLES   (GAP_CYCLES),
        .CAP_CYCLES   (CAP_CYCLES),
        .TONE_SHIFT   (TONE_SHIFT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .rx_valid_i(rx_valid),
        .rx_code_i (rx_code),
        .playing_o (playing),
        .period_o  (period)
    );

    chime_tone u_tone (
        .clk     (clk),
        .rst_n   (rst_n),
        .period_i(period),
        .buzz_o  (buzz)
    );

    assign freeze = playing;

endmodule

// File: rtl/chime_ctrl_checker.sv
module chime_ctrl_checker #(
    parameter int unsigned CAP_CYCLES = 360_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       freeze,
    input logic       buzz
);

    logic        prev_freeze;
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_freeze <= 1'b0;
            run_len     <= 0;
        end else begin
            prev_freeze <= freeze;
            run_len     <= freeze ? run_len + 1 : 0;
        end
    end

    p_tx_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    p_tx_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> $stable(tx_data));

    p_freeze_with_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> freeze);

    p_buzz_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !prev_freeze) |-> !buzz);

    p_no_retrigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && prev_freeze) |-> !tx_valid);

    p_event_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= CAP_CYCLES);

endmodule

bind chime_ctrl chime_ctrl_checker #(.CAP_CYCLES(CAP_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .freeze  (freeze),
    .buzz    (buzz)
);

// File: tb/sim_chime_ctrl.sv
`timescale 1ns/1ps
module sim_chime_ctrl;

    localparam int unsigned NI    = 200;
    localparam int unsigned GAP   = 500;
    localparam int unsigned CAP   = 2000;
    localparam int unsigned SHIFT = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] min_bcd = 8'h30;
    logic [7:0] hour_bcd = 8'h08;
    logic [7:0] temp_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic [3:0] rx_code = 4'h0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       freeze;
    logic       buzz;

    chime_ctrl #(
        .NOTE_INTERVAL(NI),
        .GAP_CYCLES   (GAP),
        .CAP_CYCLES   (CAP),
        .TONE_SHIFT   (SHIFT)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .min_bcd  (min_bcd),
        .hour_bcd (hour_bcd),
        .temp_byte(temp_byte),
        .rx_valid (rx_valid),
        .rx_code  (rx_code),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .freeze   (freeze),
        .buzz     (buzz)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    cyc;
        int    sig;
        int    val;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    localparam int SIG_TXV = 0;
    localparam int SIG_TXD = 1;
    localparam int SIG_FRZ = 2;
    localparam int SIG_BUZ = 3;

    function automatic int tone_period(input int code);
        int t;
        case (code)
            0: t = 45872;  1: t = 40858;  2: t = 36408;  3: t = 34364;
            4: t = 30612;  5: t = 27273;  6: t = 24296;  7: t = 22931;
            8: t = 20432;  9: t = 18201;  10: t = 17180; 11: t = 15306;
            12: t = 13636; 13: t = 12148; 14: t = 11478; default: t = 10215;
        endcase
        return t >> SHIFT;
    endfunction

    function automatic int read_sig(input int s);
        case (s)
            SIG_TXV: return int'(tx_valid);
            SIG_TXD: return int'(tx_data);
            SIG_FRZ: return int'(freeze);
            default: return int'(buzz);
        endcase
    endfunction

    task automatic expect_at(input int c, input int s, input int v, input string tag);
        exp_t e;
        e.cyc = c; e.sig = s; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic direct_check(input int actual, input int expected, input string tag);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic send_code(input logic [3:0] code);
        rx_valid = 1'b1;
        rx_code  = code;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare queued expectations in the middle of their cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                checks++;
                if (read_sig(sb[i].sig) != sb[i].val) begin
                    errors++;
                    $display("FAIL %s: cycle %0d signal %0d actual %0d expected %0d",
                             sb[i].tag, cyc, sb[i].sig, read_sig(sb[i].sig), sb[i].val);
                end
                sb.delete(i);
            end else if (sb[i].cyc < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s: expectation for cycle %0d missed, actual none expected %0d",
                         sb[i].tag, sb[i].cyc, sb[i].val);
                sb.delete(i);
            end
        end
    end

    initial begin
        int c, d, f;
        int p7, pf, p0;
        p7 = tone_period(7);
        pf = tone_period(15);
        p0 = tone_period(0);

        repeat (3) @(negedge clk);
        direct_check(int'(tx_valid), 0, "R11 tx_valid in reset");
        direct_check(int'(tx_data), 0, "R11 tx_data in reset");
        direct_check(int'(freeze), 0, "R11 freeze in reset");
        direct_check(int'(buzz), 0, "R11 buzz in reset");
        rst_n = 1'b1;
        wait_to(10);

        // event A: gap-terminated playback
        c = cyc;
        min_bcd   = 8'h00;
        temp_byte = 8'h5A;
        expect_at(c + 1, SIG_TXV, 1, "R1 tx pulse");
        expect_at(c + 1, SIG_FRZ, 1, "R1 freeze rises");
        expect_at(c + 1, SIG_TXD, 8'h5A, "R2 temperature byte");
        expect_at(c + 2, SIG_TXV, 0, "R2 single pulse");
        expect_at(c + 150, SIG_BUZ, 0, "R6 silent before first load");
        expect_at(c + 202, SIG_BUZ, 1, "R7 wave starts high");
        expect_at(c + 202 + p7/2 - 1, SIG_BUZ, 1, "R7 last high clock");
        expect_at(c + 202 + p7/2, SIG_BUZ, 0, "R7 low half");
        expect_at(c + 202 + p7, SIG_BUZ, 1, "R7 next period");
        expect_at(c + 302, SIG_BUZ, 0, "R6 half-interval silence");
        expect_at(c + 61, SIG_TXV, 0, "R4 retrigger ignored");
        expect_at(c + 62, SIG_TXV, 0, "R4 retrigger ignored");
        expect_at(c + 400, SIG_FRZ, 1, "R3 freeze held");
        expect_at(c + 402, SIG_BUZ, 1, "R5 code F start");
        expect_at(c + 402 + pf/2 - 1, SIG_BUZ, 1, "R5 code F high");
        expect_at(c + 402 + pf/2, SIG_BUZ, 0, "R5 code F low");
        expect_at(c + 800, SIG_FRZ, 1, "R8 before gap end");
        expect_at(c + 801, SIG_FRZ, 0, "R8 gap end");
        expect_at(c + 900, SIG_FRZ, 0, "R4 no restart while minutes stay 00");
        expect_at(c + 900, SIG_TXV, 0, "R4 no restart while minutes stay 00");
        wait_to(c + 10);  send_code(4'h7);
        wait_to(c + 50);  min_bcd = 8'h01;
        wait_to(c + 60);  min_bcd = 8'h00;
        wait_to(c + 300); send_code(4'hF);
        wait_to(c + 950); min_bcd = 8'h30;

        // event B: cap-terminated playback
        wait_to(c + 960);
        d = cyc;
        min_bcd   = 8'h00;
        temp_byte = 8'hC3;
        expect_at(d + 1, SIG_TXV, 1, "R1 second event");
        expect_at(d + 1, SIG_TXD, 8'hC3, "R2 new temperature");
        expect_at(d + 202, SIG_BUZ, 1, "R5 code 0 start");
        expect_at(d + 202 + p0/2, SIG_BUZ, 0, "R5 code 0 low half");
        expect_at(d + 2000, SIG_FRZ, 1, "R9 last capped cycle");
        expect_at(d + 2001, SIG_FRZ, 0, "R9 cap end");
        expect_at(d + 2002, SIG_TXV, 0, "R4 no restart after cap");
        expect_at(d + 2003, SIG_BUZ, 0, "R9 silent after cap");
        expect_at(d + 2100, SIG_TXD, 8'hC3, "R2 tx_data held");
        for (int k = 0; k < 8; k++) begin
            wait_to(d + 5 + 300 * k);
            send_code(4'h0);
        end

        // idle byte discarded, event C ends by gap with silence
        wait_to(d + 2200); min_bcd = 8'h30;
        wait_to(d + 2210); send_code(4'hA);
        wait_to(d + 2220);
        f = cyc;
        min_bcd = 8'h00;
        expect_at(f + 1, SIG_TXV, 1, "R1 third event");
        expect_at(f + 202, SIG_BUZ, 0, "R5 idle byte discarded");
        expect_at(f + 207, SIG_BUZ, 0, "R5 idle byte discarded");
        expect_at(f + 500, SIG_FRZ, 1, "R8 gap from start");
        expect_at(f + 501, SIG_FRZ, 0, "R8 gap from start");

        // invalid hour blocks, then hour 23 accepted
        wait_to(f + 600); min_bcd = 8'h30; hour_bcd = 8'h25;
        wait_to(f + 610); min_bcd = 8'h00;
        expect_at(f + 611, SIG_TXV, 0, "R10 hour 25 blocked");
        expect_at(f + 611, SIG_FRZ, 0, "R10 hour 25 blocked");
        wait_to(f + 620); hour_bcd = 8'h23;
        expect_at(f + 621, SIG_TXV, 1, "R10 hour 23 accepted");
        expect_at(f + 621, SIG_FRZ, 1, "R10 hour 23 accepted");
        wait_to(f + 1200);

        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule